// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Cache

This block is a direct-mapped line store that gets close to two-way hit rates by pairing every slot with a partner slot. The partner's index is the home index with its top bit inverted. A request is first looked up at its home ("fast") slot. If that misses, the partner ("slow") slot is probed one cycle later. If both miss, the block asks the next level for the line and waits for the refill. It also moves lines between the two slots of a pair, so that the line just used always ends up in the fast slot.

Each slot holds one data word per line. Each slot stores the line tag plus the top bit of the line's home index, so a line parked in its partner slot is still identified exactly. One LRU bit per slot pair picks the victim when both slots of the pair are valid. Stores allocate on a miss, exactly like loads. The block takes one request at a time: `req_ready` is low from acceptance until the response pulse.

Top module: `pac_cache`

## Requirements
- R1: After reset, all slots are invalid and `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0. The first access to any address is a miss.
- R2: The slow slot for a request is its home index (the low IDX_W address bits) with the top index bit inverted. A line held there gives a slow hit.
- R3: A hit in the fast slot gives `rsp_valid` one cycle after acceptance, with `rsp_kind` = 1 (fast) and `rsp_lat` = 0.
- R4: A slow hit responds one cycle later than a fast hit, with `rsp_kind` = 2 and `rsp_lat` = 1. It exchanges the two slots, so the next access to the same line is a fast hit and the displaced line is then a slow hit.
- R5: A request that misses both slots raises `mem_req_valid`, with `mem_addr` equal to the request address, in the third cycle after acceptance. This is one cycle later than a fast-slot-only lookup would allow. `mem_req_valid` stays high until `fill_valid`.
- R6: On a miss, the victim is chosen as follows: an invalid fast slot first, then an invalid slow slot, otherwise the least recently used slot of the pair. The refilled line is always written into the fast slot. If the slow slot is the victim, the line that was in the fast slot first moves to the slow slot. A fast hit, a slow hit and a refill each make the fast slot the most recent.
- R7: Stores are write-allocate. A store miss stalls and refills like a load miss, and the stored word replaces the line data. For stores, `rsp_rdata` returns the stored word. A later load returns it.
- R8: While `req_ready` is 0, `req_valid` is ignored, and a request presented then leaves no trace in the cache.
- R9: `rsp_lat` counts the cycles added beyond a fast hit. For a miss it is 2 plus the number of cycles `mem_req_valid` waited before `fill_valid`, and it saturates at its maximum value. `rsp_kind` = 3 marks a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_kind | output | 2 | 1 fast hit, 2 slow hit, 3 miss |
| rsp_rdata | output | DATA_W | Line data (store data for stores) |
| rsp_lat | output | LAT_W | Cycles added beyond a fast hit |
| mem_req_valid | output | 1 | Line request to next level, held until refill |
| mem_addr | output | ADDR_W | Line address requested |
| fill_valid | input | 1 | Refill data present |
| fill_data | input | DATA_W | Refill data |

## Verification
The bench runs one slot pair through a sequence of loads that first fill the pair and then land on each of its states. These include a fast slot empty with its partner empty, a fast slot full with its partner empty, and both slots full with the LRU bit pointing at either side. Each later access then tells a correct victim choice from a wrong one, and a swap from no swap, through whether it comes back as a fast hit, a slow hit or a miss. A second pair takes store misses, fast-hit stores and slow-hit stores, which separates write-allocate from data merged into the wrong slot. Refill waits of several lengths separate the latency count from a constant. A request held high while the block is busy shows whether a busy cycle can accept a request.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_FAST = 2'd1,
        RK_SLOW = 2'd2,
        RK_MISS = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FAST = 2'd1,
        ST_ALT  = 2'd2,
        ST_WAIT = 2'd3
    } pac_state_e;

    // Saturating increment helper for the latency counter.
    function automatic logic [15:0] sat_inc(input logic [15:0] v, input int unsigned w);
        logic [15:0] lim;
        lim = 16'((32'd1 << w) - 32'd1);
        return (v >= lim) ? lim : v + 16'd1;
    endfunction

endpackage

// File: rtl/pac_slot_array.sv
module pac_slot_array #(
    parameter int IDX_W  = 4,
    parameter int KEY_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    // two combinational read ports: fast slot and partner slot
    input  logic [IDX_W-1:0]  ra_idx,
    output logic              ra_valid,
    output logic [KEY_W-1:0]  ra_key,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic              rb_valid,
    output logic [KEY_W-1:0]  rb_key,
    output logic [DATA_W-1:0] rb_data,
    // write port A always writes a valid line
    input  logic              wa_en,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [KEY_W-1:0]  wa_key,
    input  logic [DATA_W-1:0] wa_data,
    // write port B carries its own valid bit (swap / move)
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic              wb_valid,
    input  logic [KEY_W-1:0]  wb_key,
    input  logic [DATA_W-1:0] wb_data
);
    localparam int SLOTS = 1 << IDX_W;

    logic              vld_q [SLOTS];
    logic [KEY_W-1:0]  key_q [SLOTS];
    logic [DATA_W-1:0] dat_q [SLOTS];

    assign ra_valid = vld_q[ra_idx];
    assign ra_key   = key_q[ra_idx];
    assign ra_data  = dat_q[ra_idx];
    assign rb_valid = vld_q[rb_idx];
    assign rb_key   = key_q[rb_idx];
    assign rb_data  = dat_q[rb_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                vld_q[i] <= 1'b0;
                key_q[i] <= '0;
                dat_q[i] <= '0;
            end
        end else begin
            if (wa_en) begin
                vld_q[wa_idx] <= 1'b1;
                key_q[wa_idx] <= wa_key;
                dat_q[wa_idx] <= wa_data;
            end
            if (wb_en) begin
                vld_q[wb_idx] <= wb_valid;
                key_q[wb_idx] <= wb_key;
                dat_q[wb_idx] <= wb_data;
            end
        end
    end

    // R4 / R6: a swap or move writes the two slots of one pair, never one slot twice
    a_r4_ports_distinct: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |-> (wa_idx != wb_idx));

    // R6: a moved line is written to the partner of the slot being refilled
    a_r6_move_partner: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |-> (wa_idx[IDX_W-1] != wb_idx[IDX_W-1]));

endmodule

// File: rtl/pac_pair_lru.sv
module pac_pair_lru #(
    parameter int PAIR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAIR_W-1:0] rd_pair,
    output logic              rd_lru_side,
    input  logic              touch_en,
    input  logic [PAIR_W-1:0] touch_pair,
    input  logic              touch_lru_side
);
    localparam int PAIRS = 1 << PAIR_W;

    // bit value = top index bit of the least recently used slot in the pair
    logic [PAIRS-1:0] lru_q;

    assign rd_lru_side = lru_q[rd_pair];

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[touch_pair] <= touch_lru_side;
        end
    end

endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
    import pac_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16,
    parameter int LAT_W  = 4,
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int KEY_W  = TAG_W + 1,
    localparam int PAIR_W = IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [LAT_W-1:0]  rsp_lat,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    // slot array
    output logic [IDX_W-1:0]  fast_idx,
    output logic [IDX_W-1:0]  alt_idx,
    input  logic              fast_valid,
    input  logic [KEY_W-1:0]  fast_key,
    input  logic [DATA_W-1:0] fast_data,
    input  logic              alt_valid,
    input  logic [KEY_W-1:0]  alt_key,
    input  logic [DATA_W-1:0] alt_data,
    output logic              wa_en,
    output logic [KEY_W-1:0]  wa_key,
    output logic [DATA_W-1:0] wa_data,
    output logic              wb_en,
    output logic              wb_valid,
    output logic [KEY_W-1:0]  wb_key,
    output logic [DATA_W-1:0] wb_data,
    // pair LRU
    output logic [PAIR_W-1:0] pair_id,
    input  logic              lru_side,
    output logic              touch_en,
    output logic              touch_side
);
    pac_state_e        state_q;
    rsp_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LAT_W-1:0]  cnt_q;
    logic [LAT_W-1:0]  cnt_nx;

    logic [KEY_W-1:0]  want_key;
    logic              home_msb;
    logic              fast_hit;
    logic              alt_hit;
    logic              evict_alt;

    assign fast_idx  = addr_q[IDX_W-1:0];
    assign home_msb  = addr_q[IDX_W-1];
    assign alt_idx   = {~home_msb, addr_q[IDX_W-2:0]};
    assign pair_id   = addr_q[IDX_W-2:0];
    assign want_key  = {addr_q[ADDR_W-1:IDX_W], home_msb};
    assign fast_hit  = fast_valid && (fast_key == want_key);
    assign alt_hit   = alt_valid && (alt_key == want_key);
    // victim: empty fast slot, else empty partner, else LRU side of pair
    assign evict_alt = fast_valid && (!alt_valid || (lru_side != home_msb));

    assign cnt_nx        = LAT_W'(sat_inc(16'(cnt_q), LAT_W));
    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_WAIT);
    assign mem_addr      = addr_q;
    assign rsp_kind      = kind_q;

    // array write and LRU update decode
    always_comb begin
        wa_en      = 1'b0;
        wa_key     = want_key;
        wa_data    = wdata_q;
        wb_en      = 1'b0;
        wb_valid   = fast_valid;
        wb_key     = fast_key;
        wb_data    = fast_data;
        touch_en   = 1'b0;
        touch_side = ~home_msb;
        unique case (state_q)
            ST_FAST: begin
                if (fast_hit) begin
                    touch_en = 1'b1;
                    wa_en    = write_q;
                end
            end
            ST_ALT: begin
                if (alt_hit) begin
                    wa_en    = 1'b1;
                    wa_data  = write_q ? wdata_q : alt_data;
                    wb_en    = 1'b1;
                    touch_en = 1'b1;
                end else if (evict_alt) begin
                    wb_en = 1'b1;
                end
            end
            ST_WAIT: begin
                if (fill_valid) begin
                    wa_en    = 1'b1;
                    wa_data  = write_q ? wdata_q : fill_data;
                    touch_en = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            kind_q    <= RK_NONE;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_lat   <= '0;
            addr_q    <= '0;
            write_q   <= 1'b0;
            wdata_q   <= '0;
            cnt_q     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            kind_q    <= RK_NONE;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        cnt_q   <= '0;
                        state_q <= ST_FAST;
                    end
                end
                ST_FAST: begin
                    cnt_q <= cnt_nx;
                    if (fast_hit) begin
                        rsp_valid <= 1'b1;
                        kind_q    <= RK_FAST;
                        rsp_rdata <= write_q ? wdata_q : fast_data;
                        rsp_lat   <= cnt_q;
                        state_q   <= ST_IDLE;
                    end else begin
                        state_q <= ST_ALT;
                    end
                end
                ST_ALT: begin
                    cnt_q <= cnt_nx;
                    if (alt_hit) begin
                        rsp_valid <= 1'b1;
                        kind_q    <= RK_SLOW;
                        rsp_rdata <= write_q ? wdata_q : alt_data;
                        rsp_lat   <= cnt_q;
                        state_q   <= ST_IDLE;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    cnt_q <= cnt_nx;
                    if (fill_valid) begin
                        rsp_valid <= 1'b1;
                        kind_q    <= RK_MISS;
                        rsp_rdata <= write_q ? wdata_q : fill_data;
                        rsp_lat   <= cnt_q;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: a response always returns the block to accepting requests
    a_r8_ready_after_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

    // R5: no next-level request while a new request could be taken
    a_r5_req_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    // R5: the next-level request rises two busy cycles after acceptance
    a_r5_req_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req_valid) |-> (!$past(req_ready) && !$past(req_ready, 2) && $past(req_ready, 3)));

    // R3: fast hit adds nothing
    a_r3_fast_lat: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == RK_FAST) |-> (rsp_lat == '0));

    // R4: slow hit adds exactly one cycle
    a_r4_slow_lat: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == RK_SLOW) |-> (rsp_lat == LAT_W'(1)));

    // R9: a miss costs at least the two probe cycles
    a_r9_miss_lat: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == RK_MISS) |-> (rsp_lat >= LAT_W'(2)));

    // R9: every response carries a real outcome code
    a_r9_kind_known: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_kind != RK_NONE));

endmodule

// File: rtl/pac_cache.sv
module pac_cache #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16,
    parameter int LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [LAT_W-1:0]  rsp_lat,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int KEY_W  = TAG_W + 1;
    localparam int PAIR_W = IDX_W - 1;

    logic [IDX_W-1:0]  fast_idx, alt_idx;
    logic              fast_valid, alt_valid;
    logic [KEY_W-1:0]  fast_key, alt_key;
    logic [DATA_W-1:0] fast_data, alt_data;
    logic              wa_en, wb_en, wb_valid;
    logic [KEY_W-1:0]  wa_key, wb_key;
    logic [DATA_W-1:0] wa_data, wb_data;
    logic [PAIR_W-1:0] pair_id;
    logic              lru_side, touch_en, touch_side;

    initial begin
        assert (IDX_W >= 2 && ADDR_W > IDX_W)
            else $error("pac_cache: IDX_W must be >= 2 and below ADDR_W");
    end

    pac_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .LAT_W(LAT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
        .rsp_lat(rsp_lat),
        .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .fast_idx(fast_idx), .alt_idx(alt_idx),
        .fast_valid(fast_valid), .fast_key(fast_key), .fast_data(fast_data),
        .alt_valid(alt_valid), .alt_key(alt_key), .alt_data(alt_data),
        .wa_en(wa_en), .wa_key(wa_key), .wa_data(wa_data),
        .wb_en(wb_en), .wb_valid(wb_valid), .wb_key(wb_key), .wb_data(wb_data),
        .pair_id(pair_id), .lru_side(lru_side),
        .touch_en(touch_en), .touch_side(touch_side)
    );

    pac_slot_array #(
        .IDX_W(IDX_W), .KEY_W(KEY_W), .DATA_W(DATA_W)
    ) u_slots (
        .clk(clk), .rst(rst),
        .ra_idx(fast_idx), .ra_valid(fast_valid), .ra_key(fast_key), .ra_data(fast_data),
        .rb_idx(alt_idx), .rb_valid(alt_valid), .rb_key(alt_key), .rb_data(alt_data),
        .wa_en(wa_en), .wa_idx(fast_idx), .wa_key(wa_key), .wa_data(wa_data),
        .wb_en(wb_en), .wb_idx(alt_idx), .wb_valid(wb_valid), .wb_key(wb_key),
        .wb_data(wb_data)
    );

    pac_pair_lru #(
        .PAIR_W(PAIR_W)
    ) u_lru (
        .clk(clk), .rst(rst),
        .rd_pair(pair_id), .rd_lru_side(lru_side),
        .touch_en(touch_en), .touch_pair(pair_id), .touch_lru_side(touch_side)
    );

endmodule

// File: tb/tb_pac_cache.sv
module tb_pac_cache;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 4;
    localparam int DATA_W = 16;
    localparam int LAT_W  = 4;

    localparam logic [1:0] K_FAST = 2'd1;
    localparam logic [1:0] K_SLOW = 2'd2;
    localparam logic [1:0] K_MISS = 2'd3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic              rsp_valid;
    logic [1:0]        rsp_kind;
    logic [DATA_W-1:0] rsp_rdata;
    logic [LAT_W-1:0]  rsp_lat;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_addr;
    logic              fill_valid = 1'b0;
    logic [DATA_W-1:0] fill_data = '0;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int mem_delay = 0;
    logic [ADDR_W-1:0] exp_mem_addr = '0;

    logic [1:0]        q_kind [$];
    logic [DATA_W-1:0] q_data [$];
    logic [LAT_W-1:0]  q_lat  [$];
    string             q_tag  [$];

    always #4 clk = ~clk;   // 8 ns period

    always @(posedge clk) cyc <= cyc + 1;

    pac_cache #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .LAT_W(LAT_W)
    ) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
        .rsp_lat(rsp_lat),
        .mem_req_valid(mem_req_valid), .mem_addr(mem_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [DATA_W-1:0] fd(input logic [ADDR_W-1:0] a);
        return {4'hC, a};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pop expected outcome on every response pulse
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (q_kind.size() == 0) begin
                    check(1'b0, "R8", "unexpected response", int'(rsp_kind), 0);
                end else begin
                    logic [1:0]        ek;
                    logic [DATA_W-1:0] ed;
                    logic [LAT_W-1:0]  el;
                    string             et;
                    ek = q_kind.pop_front();
                    ed = q_data.pop_front();
                    el = q_lat.pop_front();
                    et = q_tag.pop_front();
                    check(rsp_kind == ek, et, "kind", int'(rsp_kind), int'(ek));
                    check(rsp_rdata == ed, et, "data", int'(rsp_rdata), int'(ed));
                    check(rsp_lat == el, et, "lat", int'(rsp_lat), int'(el));
                end
            end
        end
    end

    // next-level model: checks request timing and address, refills after a delay
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_req_valid) begin
                check(cyc - acc_cyc == 2, "R5", "request cycle", cyc - acc_cyc, 2);
                check(mem_addr == exp_mem_addr, "R5", "request addr",
                      int'(mem_addr), int'(exp_mem_addr));
                repeat (mem_delay) @(negedge clk);
                fill_valid = 1'b1;
                fill_data  = fd(mem_addr);
                @(negedge clk);
                fill_valid = 1'b0;
            end
        end
    end

    task automatic do_req(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input logic [1:0] k,
                          input logic [DATA_W-1:0] d, input int lat, input int delay,
                          input string tag, input bit junk);
        q_kind.push_back(k);
        q_data.push_back(d);
        q_lat.push_back(LAT_W'(lat));
        q_tag.push_back(tag);
        mem_delay    = delay;
        exp_mem_addr = a;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        acc_cyc   = cyc + 1;
        @(negedge clk);
        if (junk) begin
            // R8: store to 0x077 held while busy must be ignored
            req_valid = 1'b1;
            req_write = 1'b1;
            req_addr  = 12'h077;
            req_wdata = 16'hDEAD;
        end else begin
            req_valid = 1'b0;
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b0;
        while (q_kind.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
        check(mem_req_valid == 1'b0, "R1", "mem_req", int'(mem_req_valid), 0);

        // pair (2,10): A,B,C,E home 2; D home 10
        do_req(0, 12'h012, 0, K_MISS, fd(12'h012), 2, 0, "R1", 0);
        do_req(0, 12'h012, 0, K_FAST, fd(12'h012), 0, 0, "R3", 0);
        do_req(0, 12'h022, 0, K_MISS, fd(12'h022), 5, 3, "R9", 0);  // A moves to 10
        do_req(0, 12'h012, 0, K_SLOW, fd(12'h012), 1, 0, "R2", 0);  // swap
        do_req(0, 12'h012, 0, K_FAST, fd(12'h012), 0, 0, "R4", 0);
        do_req(0, 12'h022, 0, K_SLOW, fd(12'h022), 1, 0, "R4", 0);  // B fast, A LRU
        do_req(0, 12'h032, 0, K_MISS, fd(12'h032), 2, 0, "R6", 0);  // A evicted, B to 10
        do_req(0, 12'h022, 0, K_SLOW, fd(12'h022), 1, 0, "R6", 0);  // C now LRU
        do_req(0, 12'h012, 0, K_MISS, fd(12'h012), 3, 1, "R6", 0);  // C evicted
        do_req(0, 12'h01A, 0, K_MISS, fd(12'h01A), 2, 0, "R6", 0);  // B (fast for D) evicted
        do_req(0, 12'h01A, 0, K_FAST, fd(12'h01A), 0, 0, "R3", 0);
        do_req(0, 12'h042, 0, K_MISS, fd(12'h042), 2, 0, "R6", 0);  // A (fast, LRU) evicted
        do_req(0, 12'h01A, 0, K_FAST, fd(12'h01A), 0, 0, "R6", 0);  // D untouched
        do_req(0, 12'h012, 0, K_MISS, fd(12'h012), 2, 0, "R6", 0);

        // pair (5,13): stores
        do_req(1, 12'h055, 16'hBEEF, K_MISS, 16'hBEEF, 4, 2, "R7", 0);
        do_req(0, 12'h055, 0, K_FAST, 16'hBEEF, 0, 0, "R7", 0);
        do_req(1, 12'h055, 16'h1234, K_FAST, 16'h1234, 0, 0, "R7", 0);
        do_req(0, 12'h055, 0, K_FAST, 16'h1234, 0, 0, "R7", 0);
        do_req(0, 12'h065, 0, K_MISS, fd(12'h065), 2, 0, "R6", 0);  // F moves to 13
        do_req(1, 12'h055, 16'h7777, K_SLOW, 16'h7777, 1, 0, "R7", 0);
        do_req(0, 12'h055, 0, K_FAST, 16'h7777, 0, 0, "R4", 0);
        do_req(0, 12'h065, 0, K_SLOW, fd(12'h065), 1, 0, "R4", 0);

        // busy-time request ignored, long refill wait
        do_req(0, 12'h032, 0, K_MISS, fd(12'h032), 9, 7, "R9", 1);
        do_req(0, 12'h077, 0, K_MISS, fd(12'h077), 2, 0, "R8", 0);

        repeat (4) @(negedge clk);
        check(q_kind.size() == 0, "R8", "pending responses", q_kind.size(), 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule